// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block schedules conversions for a successive-approximation converter. It watches a sample-trigger line and an enable bit. From them it decides when a run of conversions begins, which channel each conversion uses, and when the run ends. Inside the block, the converter is a model with a fixed latency: a one-cycle start pulse is followed `CONV_LAT` cycles later by an internal completion event.

A run converts either a single channel or a descending sequence of channels, and it happens once or repeats. When the auto-chain bit is set, each conversion after the first starts as soon as the previous one completes. When the bit is clear, every conversion waits for its own trigger edge. How a run stops depends on the mode. Clearing enable can abort at once, stop after the conversion in flight, or stop at the end of the current pass through the sequence.

Top module: `adcs_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `conv_start_o`, `busy_o` and `result_valid_o` are 0 and `chan_o` is 0.
- R2: A run starts only in the idle state, on a rising edge of `trig_i` (high now, low in the previous cycle) while `en_i` is high. Mode encoding on `mode_i`: 0 = one channel once, 1 = sequence once, 2 = one channel repeated, 3 = sequence repeated. A trigger edge while `en_i` is low starts nothing.
- R3: In the cycle after an accepted edge, `conv_start_o` is high for exactly one cycle, `busy_o` rises, and `chan_o` equals `start_ch_i`.
- R4: `result_valid_o` is a one-cycle strobe. It rises exactly `CONV_LAT`+1 cycles after the `conv_start_o` of the conversion it reports.
- R5: In sequence modes, each conversion uses a channel one lower than the previous one, down to channel 0. In mode 3, the pass after channel 0 restarts at the latched start channel.
- R6: With `multi_i` set when the run is accepted, the next `conv_start_o` comes in the same cycle as the previous `result_valid_o`, with no trigger needed. Trigger edges during the run start nothing extra.
- R7: With `multi_i` clear, each conversion after the first waits for a new trigger rising edge. Edges that arrive while a conversion is in progress are ignored.
- R8: A run in mode 0 or mode 1 ends by itself after its last conversion. `busy_o` falls in the same cycle as the final `result_valid_o`.
- R9: In modes 2 and 3, conversions go on until `en_i` is cleared. In mode 2, the run then ends with the conversion in flight, so at most one more result follows the clear.
- R10: In mode 3, after `en_i` is cleared, the pass in progress finishes down to channel 0 and the run then ends, with no further start.
- R11: If `en_i` is low while `mode_i` is 0, or while the run's mode is 0, an active run aborts. `busy_o` is low in the next cycle, and no `result_valid_o` is given for the aborted conversion, even when it completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Sample-trigger line; rising edges matter |
| en_i | input | 1 | Conversion enable |
| mode_i | input | 2 | Run mode select (0..3, see R2) |
| multi_i | input | 1 | Auto-chain conversions after the first trigger |
| start_ch_i | input | CHAN_W | Channel of the first conversion of a pass |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| chan_o | output | CHAN_W | Channel of the current conversion |
| busy_o | output | 1 | A run is in progress |
| result_valid_o | output | 1 | One-cycle strobe: a conversion result is good |

## Verification
The hard case is when a conversion completes in the very cycle that an abort is requested. The abort must win, so no result is reported and no further conversion starts. The bench provokes this by counting `CONV_LAT` cycles from an observed start pulse and then dropping enable with mode 0 exactly as the converter finishes. It judges the outcome from the absence of any strobe and of any unexpected start pulse, which the scoreboard would flag. The other overlap is a result strobe and the next start pulse under auto-chaining. The bench checks that both appear in the same cycle.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    typedef enum logic [1:0] {
        MD_ONE      = 2'd0,
        MD_SEQ      = 2'd1,
        MD_RPT_ONE  = 2'd2,
        MD_RPT_SEQ  = 2'd3
    } conv_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        conv_mode_e mode;
        logic       multi;
    } run_cfg_t;

    function automatic logic mode_is_seq(conv_mode_e m);
        return (m == MD_SEQ) || (m == MD_RPT_SEQ);
    endfunction

    function automatic logic mode_is_repeat(conv_mode_e m);
        return (m == MD_RPT_ONE) || (m == MD_RPT_SEQ);
    endfunction

endpackage

// File: rtl/adcs_edge.sv
module adcs_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/adcs_conv.sv
module adcs_conv #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic abort_i,
    output logic done_o,
    output logic run_o
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LAT - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (abort_i) begin
            run_q <= 1'b0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= LOAD;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done_o = run_q && (cnt_q == '0);
    assign run_o  = run_q;

    a_r11_abort_kills_done: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !done_o);
    a_r4_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/adcs_chan_step.sv
module adcs_chan_step
    import adcs_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  conv_mode_e        mode_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [CHAN_W-1:0] base_i,
    output logic              pass_end_o,
    output logic [CHAN_W-1:0] next_o
);
    always_comb begin
        pass_end_o = !mode_is_seq(mode_i) || (chan_i == '0);
        next_o     = pass_end_o ? base_i : (chan_i - CHAN_W'(1));
    end
endmodule

// File: rtl/adcs_ctrl.sv
module adcs_ctrl
    import adcs_pkg::*;
#(
    parameter int CHAN_W   = 3,
    parameter int CONV_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              en_i,
    input  logic [1:0]        mode_i,
    input  logic              multi_i,
    input  logic [CHAN_W-1:0] start_ch_i,
    output logic              conv_start_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              busy_o,
    output logic              result_valid_o
);
    ctrl_state_e       state_q;
    run_cfg_t          cfg_q;
    logic [CHAN_W-1:0] base_q, chan_q;
    logic              busy_q, start_q, valid_q, stop_q, head_q;

    logic              trig_rise, conv_done, conv_run;
    logic              pass_end, stop_now, abort, finish;
    logic [CHAN_W-1:0] next_chan;

    adcs_edge u_edge (
        .clk(clk), .rst(rst), .sig_i(trig_i), .rise_o(trig_rise)
    );

    adcs_conv #(.LAT(CONV_LAT)) u_conv (
        .clk(clk), .rst(rst), .start_i(start_q),
        .abort_i(abort && (state_q == ST_CONV)),
        .done_o(conv_done), .run_o(conv_run)
    );

    adcs_chan_step #(.CHAN_W(CHAN_W)) u_step (
        .mode_i(cfg_q.mode), .chan_i(chan_q), .base_i(base_q),
        .pass_end_o(pass_end), .next_o(next_chan)
    );

    always_comb begin
        stop_now = stop_q || !en_i;
        abort    = (state_q != ST_IDLE) && !en_i &&
                   ((conv_mode_e'(mode_i) == MD_ONE) || (cfg_q.mode == MD_ONE));
        finish   = pass_end && (!mode_is_repeat(cfg_q.mode) || stop_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '{mode: MD_ONE, multi: 1'b0};
            base_q  <= '0;
            chan_q  <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            valid_q <= 1'b0;
            stop_q  <= 1'b0;
            head_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            valid_q <= 1'b0;
            if ((state_q != ST_IDLE) && !en_i) stop_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (en_i && trig_rise) begin
                        cfg_q   <= '{mode: conv_mode_e'(mode_i), multi: multi_i};
                        base_q  <= start_ch_i;
                        chan_q  <= start_ch_i;
                        stop_q  <= 1'b0;
                        head_q  <= 1'b1;
                        busy_q  <= 1'b1;
                        start_q <= 1'b1;
                        state_q <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (abort) begin
                        busy_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else if (conv_done) begin
                        valid_q <= 1'b1;
                        if (finish) begin
                            busy_q  <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            chan_q <= next_chan;
                            head_q <= pass_end;
                            if (cfg_q.multi) start_q <= 1'b1;
                            else             state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (abort || (stop_now && head_q && mode_is_repeat(cfg_q.mode))) begin
                        busy_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else if (trig_rise) begin
                        start_q <= 1'b1;
                        state_q <= ST_CONV;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_start_o   = start_q;
    assign chan_o         = chan_q;
    assign busy_o         = busy_q;
    assign result_valid_o = valid_q;

    a_r3_start_inside_run: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> busy_o);
    a_r4_valid_after_done: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> $past(conv_done));
    a_r11_abort_silences: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy_o && !result_valid_o));
    a_r2_no_start_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !en_i) |=> !conv_start_o);
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        conv_run |-> !conv_start_o);
endmodule

// File: tb/sim_adcs_ctrl.sv
module sim_adcs_ctrl;
    localparam int CW  = 3;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0, en = 1'b0, multi = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [CW-1:0] sch = '0;
    logic          cstart, busy, valid;
    logic [CW-1:0] chan;

    adcs_ctrl #(.CHAN_W(CW), .CONV_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .trig_i(trig), .en_i(en), .mode_i(mode),
        .multi_i(multi), .start_ch_i(sch), .conv_start_o(cstart),
        .chan_o(chan), .busy_o(busy), .result_valid_o(valid)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    int n_start = 0, n_valid = 0;
    int exp_q[$];
    bit fr_on = 0, fr_seq = 0;
    int fr_base = 0, fr_exp = 0, last_ch = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (valid) n_valid++;
            if (cstart) begin
                n_start++;
                last_ch = int'(chan);
                if (fr_on) begin
                    chk(int'(chan) == fr_exp, "R5 free-run channel", int'(chan), fr_exp);
                    fr_exp = fr_seq ? ((chan == 0) ? fr_base : int'(chan) - 1) : fr_base;
                end else if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected start", int'(chan), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(chan) == e, "R5 scoreboard channel", int'(chan), e);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic setup(input int md, input bit mu, input int s);
        mode = 2'(md); multi = mu; sch = CW'(s); en = 1'b1;
    endtask

    initial begin : wdog
        int c;
        for (c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) disable wdog;
        end
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0, v0;
        cyc(3);
        chk(!cstart && !busy && !valid && chan == 0, "R1 reset outputs", int'(busy), 0);
        rst = 1'b0;
        cyc(1);
        chk(!cstart && !busy && !valid && chan == 0, "R1 after release", int'(busy), 0);

        // R2: trigger with enable low
        setup(0, 0, 5); en = 1'b0; s0 = n_start;
        pulse; cyc(LAT + 3);
        chk(n_start == s0 && !busy, "R2 disabled trigger ignored", n_start - s0, 0);

        // R3/R4/R8: one channel once
        setup(0, 0, 5); exp_q.push_back(5); v0 = n_valid;
        pulse;
        chk(cstart && busy && chan == 5, "R3 start after edge", int'(chan), 5);
        cyc(1);
        chk(!cstart, "R3 start one cycle", int'(cstart), 0);
        cyc(LAT - 1);
        chk(!valid, "R4 not early", int'(valid), 0);
        cyc(1);
        chk(valid && !busy, "R4 R8 valid at LAT+1 with busy low", int'(valid), 1);
        cyc(1);
        chk(!valid && n_valid - v0 == 1, "R4 single strobe", n_valid - v0, 1);

        // R6/R5/R8: sequence once, auto-chained
        setup(1, 1, 3); exp_q.push_back(3); exp_q.push_back(2);
        exp_q.push_back(1); exp_q.push_back(0);
        v0 = n_valid; s0 = n_start;
        pulse; cyc(2); pulse;
        cyc(LAT - 2);
        chk(valid && cstart, "R6 chained start with valid", int'(cstart), 1);
        cyc(3 * (LAT + 1) + 3);
        chk(!busy && n_valid - v0 == 4, "R8 sequence results", n_valid - v0, 4);
        chk(n_start - s0 == 4, "R6 edges ignored during run", n_start - s0, 4);

        // R7: sequence once, one trigger per conversion
        setup(1, 0, 2); exp_q.push_back(2); exp_q.push_back(1); exp_q.push_back(0);
        v0 = n_valid; s0 = n_start;
        pulse; cyc(1); pulse;
        cyc(LAT + 4);
        chk(busy && n_start - s0 == 1, "R7 waits for edge", n_start - s0, 1);
        pulse; cyc(LAT + 3);
        chk(n_start - s0 == 2, "R7 second edge starts", n_start - s0, 2);
        pulse; cyc(LAT + 3);
        chk(!busy && n_valid - v0 == 3, "R7 R8 sequence complete", n_valid - v0, 3);

        // R9: repeat one channel, stop after current conversion
        setup(2, 1, 4); fr_on = 1; fr_seq = 0; fr_base = 4; fr_exp = 4;
        v0 = n_valid; s0 = n_start;
        pulse; cyc(3 * (LAT + 1)); pulse; cyc(2);
        chk(busy && n_start - s0 >= 3, "R9 keeps repeating", n_start - s0, 3);
        en = 1'b0;
        begin
            int vc;
            vc = n_valid;
            cyc(LAT + 4);
            chk(!busy && n_valid - vc <= 1, "R9 stops after current", n_valid - vc, 1);
        end
        chk(n_valid - v0 == n_start - s0, "R9 every start reported", n_valid - v0, n_start - s0);

        // R10: repeat sequence, finish pass after enable clear
        setup(3, 1, 2); fr_seq = 1; fr_base = 2; fr_exp = 2;
        v0 = n_valid; s0 = n_start;
        pulse; cyc(4 * (LAT + 1) + 1);
        en = 1'b0;
        cyc(4 * (LAT + 1));
        chk(!busy && last_ch == 0, "R10 pass ends at channel 0", last_ch, 0);
        chk(n_valid - v0 == n_start - s0 && n_start - s0 == 6, "R10 run length", n_start - s0, 6);

        // R11: mode 0 with enable low stops repeat sequence at once
        setup(3, 1, 3); fr_base = 3; fr_exp = 3;
        v0 = n_valid; s0 = n_start;
        pulse; cyc(2 * (LAT + 1) + 2);
        mode = 2'd0; en = 1'b0;
        cyc(1);
        chk(!busy, "R11 forced stop busy low", int'(busy), 0);
        cyc(LAT + 3);
        chk(n_valid - v0 == n_start - s0 - 1, "R11 forced stop no result", n_valid - v0, n_start - s0 - 1);
        fr_on = 0;

        // R11: abort single conversion, then a clean run
        setup(0, 0, 6); exp_q.push_back(6); v0 = n_valid;
        pulse; cyc(1); en = 1'b0; cyc(1);
        chk(!busy, "R11 abort busy low", int'(busy), 0);
        cyc(LAT + 2);
        chk(n_valid == v0, "R11 aborted no valid", n_valid - v0, 0);
        setup(0, 0, 6); exp_q.push_back(6);
        pulse; cyc(LAT + 2);
        chk(n_valid - v0 == 1 && !busy, "R11 clean run after abort", n_valid - v0, 1);

        // R11: abort in the same cycle as completion
        setup(1, 1, 1); exp_q.push_back(1); v0 = n_valid; s0 = n_start;
        pulse; cyc(LAT);
        mode = 2'd0; en = 1'b0;
        cyc(1);
        chk(!valid && !busy, "R11 abort beats done", int'(valid), 0);
        cyc(LAT + 3);
        chk(n_valid == v0 && n_start - s0 == 1, "R11 no result no restart", n_valid - v0, 0);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule